// File: doc/BRIEF.md
# Receive Frame Ring with Word-Wide Host Readout

This block takes received Ethernet frames as a byte stream, marked with start and end flags, and stores each accepted frame in one slot of a ring of fixed-size slots. While a frame is stored it is zero-padded to the 60-byte minimum and a CRC-32 is appended. Each stored slot is later presented to the host with a two-word header. The first header word is a fixed marker. The second carries the stored length and a status field.

The host drains frames through a single data register, one 32-bit word per read strobe. The block advances to the next slot by itself once the header and the stored length have been consumed. A pending-frame count is always visible, and writing zero to the count register discards everything pending. A single receive status bit (bit 8) is set whenever a frame is stored. It drives an interrupt through a mask and is cleared by writing a 1 to that bit.

The intake is a state machine with states IN_IDLE, IN_RECV, IN_PAD, IN_FCS, IN_DONE and IN_DISCARD. It moves between them as follows:
- IN_IDLE goes to IN_RECV on an accepted start byte. A one-byte frame goes straight to IN_PAD.
- A start byte that is refused moves IN_IDLE to IN_DISCARD, unless that byte also carries the end flag; then the machine stays in IN_IDLE.
- IN_RECV goes to IN_PAD on the end byte of a frame shorter than 60 bytes, and to IN_FCS on the end byte of a longer one.
- IN_RECV leaves on a byte beyond the slot capacity. It goes to IN_DISCARD, or back to IN_IDLE if that byte is the last one.
- IN_PAD goes to IN_FCS once the 60th byte is written.
- IN_FCS goes to IN_DONE after the fourth CRC byte.
- IN_DONE stores the frame in one cycle and returns to IN_IDLE.
- IN_DISCARD returns to IN_IDLE on the end byte.

Top module: `rx_frame_ring`

## Requirements
- R1: A frame is accepted only if `rx_en` is 1 in the cycle of its start byte. A frame refused this way leaves `pending` unchanged.
- R2: A frame whose byte count plus 8 exceeds SLOT_BYTES is dropped. A frame of exactly SLOT_BYTES-8 bytes is stored.
- R3: A frame that starts while NUM_SLOTS frames are pending is dropped, and `pending` never exceeds NUM_SLOTS.
- R4: A frame shorter than 60 bytes is extended with zero bytes to 60 bytes before the CRC is appended.
- R5: After the padded data come four CRC bytes, least significant byte first. The CRC uses the reflected polynomial 0xEDB88320 with initial value 0xFFFFFFFF and final inversion, over the padded data.
- R6: The first word read from a slot is 0x0143414D. The second word is {16'h0080, L}, where L is the padded length plus 4 and bit 7 of the upper half means good status.
- R7: Stored bytes are packed little-endian, with the first byte of each word in bits 7:0. Byte lanes past the end of the data in the final word read as zero.
- R8: Each `data_rd` strobe advances to the next word of the oldest frame. After ceil((L+8)/4) strobes on one frame, `pending` drops by one and the next frame's header follows.
- R9: With no frame pending, `rd_data` is 0, and a `data_rd` strobe changes nothing.
- R10: A count write with value 0 discards all pending frames. A count write with any other value has no effect.
- R11: Storing a frame sets status bit 8. `irq` is status bit 8 AND `irq_mask[8]`. A status write clears bit 8 only when its bit 8 is 1. A store in the same cycle wins over the clear.
- R12: Frames are read out in arrival order, including across the wrap of the slot index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Receive enable, sampled at each frame start |
| rx_valid | input | 1 | A received byte is present on `rx_data` |
| rx_data | input | 8 | Received byte |
| rx_sof | input | 1 | This byte is the first of a frame |
| rx_eof | input | 1 | This byte is the last of a frame |
| data_rd | input | 1 | Read strobe of the data register; consumes `rd_data` |
| cnt_wr | input | 1 | Write strobe of the frame-count register |
| cnt_wdata | input | 32 | Frame-count write value (0 discards all) |
| sta_wr | input | 1 | Write strobe of the status register |
| sta_wdata | input | 32 | Status write value, a 1 in bit 8 clears that bit |
| irq_mask | input | 32 | Interrupt enable, bit 8 gates the receive status |
| rd_data | output | 32 | Current word of the data register |
| pending | output | $clog2(NUM_SLOTS+1) | Number of stored, unread frames |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with NUM_SLOTS=3 and SLOT_BYTES=128. The smaller values make the 120-byte capacity edge, the full ring and the slot-index wrap reachable within a few hundred cycles. With them, the 121-byte drop, the refusal of a fourth frame and a frame stored in slot 0 after slot 2 all occur within one short run. Frames of 10, 45 and 61 bytes cover padding and a final word with one valid byte. A behavioural model then compares the data word, count and interrupt against the design in every cycle.

// File: rtl/rx_frame_ring_pkg.sv
package rx_frame_ring_pkg;

    localparam logic [31:0] SLOT_MARKER   = 32'h0143_414D;
    localparam logic [15:0] STATUS_GOOD   = 16'h0080;
    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;
    localparam int          HDR_BYTES     = 8;
    localparam int          FCS_BYTES     = 4;
    localparam int          MIN_FRAME     = 60;
    localparam int          RX_IRQ_BIT    = 8;

    typedef enum logic [2:0] {
        IN_IDLE,
        IN_RECV,
        IN_PAD,
        IN_FCS,
        IN_DONE,
        IN_DISCARD
    } intake_state_t;

    // One byte of a reflected CRC-32, least significant bit first.
    function automatic logic [31:0] crc32_step(input logic [31:0] crc_in,
                                               input logic [7:0]  data);
        logic [31:0] c;
        c = crc_in ^ {24'h0, data};
        for (int k = 0; k < 8; k++) begin
            c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/rxr_intake.sv
module rxr_intake
    import rx_frame_ring_pkg::*;
#(
    parameter int SLOT_BYTES = 2048,
    parameter int BC_W       = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rx_en,
    input  logic            rx_valid,
    input  logic [7:0]      rx_data,
    input  logic            rx_sof,
    input  logic            rx_eof,
    input  logic            ring_full,
    output logic            wr_en,
    output logic [BC_W-1:0] wr_bidx,
    output logic [7:0]      wr_byte,
    output logic            commit,
    output logic [15:0]     commit_len
);

    localparam int              MAX_DATA   = SLOT_BYTES - HDR_BYTES;
    localparam logic [BC_W-1:0] MAX_DATA_C = BC_W'(MAX_DATA);

    intake_state_t   state, state_nxt;
    logic [BC_W-1:0] bcnt;
    logic [31:0]     crc;
    logic [1:0]      fcs_idx;
    logic            take;
    logic            start_ok;

    assign start_ok = rx_valid && rx_sof && rx_en && !ring_full;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= IN_IDLE;
        else        state <= state_nxt;
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            IN_IDLE: begin
                if (rx_valid && rx_sof) begin
                    if (start_ok)
                        state_nxt = rx_eof ? ((1 < MIN_FRAME) ? IN_PAD : IN_FCS) : IN_RECV;
                    else
                        state_nxt = rx_eof ? IN_IDLE : IN_DISCARD;
                end
            end
            IN_RECV: begin
                if (rx_valid) begin
                    if (bcnt == MAX_DATA_C)
                        state_nxt = rx_eof ? IN_IDLE : IN_DISCARD;
                    else if (rx_eof)
                        state_nxt = (int'(bcnt) + 1 < MIN_FRAME) ? IN_PAD : IN_FCS;
                end
            end
            IN_PAD:     if (int'(bcnt) + 1 == MIN_FRAME) state_nxt = IN_FCS;
            IN_FCS:     if (fcs_idx == 2'd3) state_nxt = IN_DONE;
            IN_DONE:    state_nxt = IN_IDLE;
            IN_DISCARD: if (rx_valid && rx_eof) state_nxt = IN_IDLE;
            default:    state_nxt = IN_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        take       = (state == IN_IDLE && start_ok) ||
                     (state == IN_RECV && rx_valid && bcnt != MAX_DATA_C);
        wr_en      = take || state == IN_PAD || state == IN_FCS;
        wr_bidx    = (state == IN_IDLE) ? '0 : bcnt;
        wr_byte    = 8'h00;
        if (take)
            wr_byte = rx_data;
        else if (state == IN_FCS)
            wr_byte = ~crc[8*fcs_idx +: 8];
        commit     = (state == IN_DONE);
        commit_len = 16'(bcnt);
    end

    // Byte counter, running CRC and FCS byte index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bcnt    <= '0;
            crc     <= '1;
            fcs_idx <= '0;
        end else if (take || state == IN_PAD) begin
            crc  <= crc32_step((state == IN_IDLE) ? 32'hFFFF_FFFF : crc, wr_byte);
            bcnt <= ((state == IN_IDLE) ? '0 : bcnt) + 1'b1;
        end else if (state == IN_FCS) begin
            bcnt    <= bcnt + 1'b1;
            fcs_idx <= fcs_idx + 1'b1;
        end else if (state == IN_IDLE) begin
            fcs_idx <= '0;
        end
    end

endmodule

// File: rtl/rxr_slot_store.sv
module rxr_slot_store #(
    parameter int NUM_SLOTS  = 12,
    parameter int DATA_WORDS = 511,
    parameter int BC_W       = 12,
    parameter int SLOT_W     = 4
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [BC_W-1:0]   wr_bidx,
    input  logic [7:0]        wr_byte,
    input  logic [SLOT_W-1:0] rd_slot,
    input  logic [BC_W-1:0]   rd_word,
    output logic [31:0]       rd_word_data
);

    localparam int DEPTH = NUM_SLOTS * DATA_WORDS;
    localparam int AW    = $clog2(DEPTH);

    logic [31:0]   mem [DEPTH];
    logic [AW-1:0] wa, ra;

    assign wa = AW'(int'(wr_slot) * DATA_WORDS + int'(wr_bidx >> 2));
    assign ra = AW'(int'(rd_slot) * DATA_WORDS + int'(rd_word));

    // Lane 0 opens a fresh word and clears the upper lanes.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            if (wr_bidx[1:0] == 2'd0)
                mem[wa] <= {24'h0, wr_byte};
            else
                mem[wa][8*wr_bidx[1:0] +: 8] <= wr_byte;
        end
    end

    assign rd_word_data = mem[ra];

endmodule

// File: rtl/rxr_ring_ctl.sv
module rxr_ring_ctl
    import rx_frame_ring_pkg::*;
#(
    parameter int NUM_SLOTS = 12,
    parameter int SLOT_W    = 4,
    parameter int CNT_W     = 4,
    parameter int BC_W      = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [15:0]       commit_len,
    input  logic              data_rd,
    input  logic              cnt_wr,
    input  logic [31:0]       cnt_wdata,
    input  logic [31:0]       store_word,
    output logic [SLOT_W-1:0] tail,
    output logic [SLOT_W-1:0] head,
    output logic [BC_W-1:0]   store_idx,
    output logic [CNT_W-1:0]  count,
    output logic              ring_full,
    output logic [31:0]       rd_data
);

    logic [15:0]     len_arr [NUM_SLOTS];
    logic [BC_W-1:0] rd_idx;
    logic [CNT_W-1:0] count_nxt;
    logic [15:0]     cur_len;
    logic            flush, pop, last_word;

    function automatic logic [SLOT_W-1:0] slot_inc(input logic [SLOT_W-1:0] s);
        return (s == SLOT_W'(NUM_SLOTS - 1)) ? '0 : s + 1'b1;
    endfunction

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_len
        logic [15:0] len_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                len_q <= '0;
            else if (commit && tail == SLOT_W'(g))
                len_q <= commit_len;
        end
        assign len_arr[g] = len_q;
    end

    assign cur_len   = len_arr[head];
    assign flush     = cnt_wr && (cnt_wdata == 32'h0);
    assign pop       = data_rd && (count != '0) && !flush;
    assign last_word = (int'(rd_idx) + 1) == ((int'(cur_len) + HDR_BYTES + 3) >> 2);
    assign ring_full = (count == CNT_W'(NUM_SLOTS));
    assign store_idx = rd_idx - BC_W'(2);

    always_comb begin
        count_nxt = count;
        if (flush)
            count_nxt = '0;
        else if (pop && last_word)
            count_nxt = count - 1'b1;
        if (commit)
            count_nxt = count_nxt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head   <= '0;
            tail   <= '0;
            count  <= '0;
            rd_idx <= '0;
        end else begin
            count <= count_nxt;
            if (commit) tail <= slot_inc(tail);
            if (flush) begin
                head   <= tail;
                rd_idx <= '0;
            end else if (pop) begin
                if (last_word) begin
                    head   <= slot_inc(head);
                    rd_idx <= '0;
                end else begin
                    rd_idx <= rd_idx + 1'b1;
                end
            end
        end
    end

    always_comb begin
        if (count == '0)
            rd_data = 32'h0;
        else if (rd_idx == '0)
            rd_data = SLOT_MARKER;
        else if (rd_idx == BC_W'(1))
            rd_data = {STATUS_GOOD, cur_len};
        else
            rd_data = store_word;
    end

endmodule

// File: rtl/rx_frame_ring.sv
module rx_frame_ring
    import rx_frame_ring_pkg::*;
#(
    parameter int NUM_SLOTS  = 12,
    parameter int SLOT_BYTES = 2048
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           rx_en,
    input  logic                           rx_valid,
    input  logic [7:0]                     rx_data,
    input  logic                           rx_sof,
    input  logic                           rx_eof,
    input  logic                           data_rd,
    input  logic                           cnt_wr,
    input  logic [31:0]                    cnt_wdata,
    input  logic                           sta_wr,
    input  logic [31:0]                    sta_wdata,
    input  logic [31:0]                    irq_mask,
    output logic [31:0]                    rd_data,
    output logic [$clog2(NUM_SLOTS+1)-1:0] pending,
    output logic                           irq
);

    localparam int CNT_W      = $clog2(NUM_SLOTS + 1);
    localparam int SLOT_W     = $clog2(NUM_SLOTS);
    localparam int BC_W       = $clog2(SLOT_BYTES + FCS_BYTES + 1);
    localparam int DATA_WORDS = (SLOT_BYTES - HDR_BYTES + FCS_BYTES + 3) / 4;

    logic              wr_en, commit, ring_full, rx_flag;
    logic [BC_W-1:0]   wr_bidx, store_idx;
    logic [7:0]        wr_byte;
    logic [15:0]       commit_len;
    logic [SLOT_W-1:0] tail, head;
    logic [31:0]       store_word;

    rxr_intake #(.SLOT_BYTES(SLOT_BYTES), .BC_W(BC_W)) intake_i (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .ring_full(ring_full), .wr_en(wr_en), .wr_bidx(wr_bidx),
        .wr_byte(wr_byte), .commit(commit), .commit_len(commit_len)
    );

    rxr_slot_store #(.NUM_SLOTS(NUM_SLOTS), .DATA_WORDS(DATA_WORDS),
                     .BC_W(BC_W), .SLOT_W(SLOT_W)) store_i (
        .clk(clk), .wr_en(wr_en), .wr_slot(tail), .wr_bidx(wr_bidx),
        .wr_byte(wr_byte), .rd_slot(head), .rd_word(store_idx),
        .rd_word_data(store_word)
    );

    rxr_ring_ctl #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .CNT_W(CNT_W),
                   .BC_W(BC_W)) ring_i (
        .clk(clk), .rst_n(rst_n), .commit(commit), .commit_len(commit_len),
        .data_rd(data_rd), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .store_word(store_word), .tail(tail), .head(head),
        .store_idx(store_idx), .count(pending), .ring_full(ring_full),
        .rd_data(rd_data)
    );

    // Receive status bit: a store wins over a same-cycle clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rx_flag <= 1'b0;
        else if (commit)
            rx_flag <= 1'b1;
        else if (sta_wr && sta_wdata[RX_IRQ_BIT])
            rx_flag <= 1'b0;
    end

    assign irq = rx_flag & irq_mask[RX_IRQ_BIT];

endmodule

// File: rtl/rx_frame_ring_chk.sv
module rx_frame_ring_chk #(
    parameter int NUM_SLOTS = 12,
    parameter int CNT_W     = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] pending,
    input logic [31:0]      rd_data,
    input logic             irq,
    input logic [31:0]      irq_mask,
    input logic             data_rd,
    input logic             cnt_wr,
    input logic [31:0]      cnt_wdata,
    input logic             sta_wr,
    input logic [31:0]      sta_wdata,
    input logic             commit
);

    p_pending_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pending) <= NUM_SLOTS);

    p_empty_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pending == '0) |-> (rd_data == 32'h0));

    p_empty_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && pending == '0 && !commit) |=> (pending == '0));

    p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr && cnt_wdata == 32'h0) |=> (int'(pending) <= 1));

    p_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(cnt_wr && cnt_wdata == 32'h0) |=>
            (pending == $past(pending) || pending == $past(pending) + 1'b1 ||
             pending + 1'b1 == $past(pending)));

    p_irq_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (irq || !irq_mask[8]));

    p_irq_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sta_wr && sta_wdata[8] && !commit) |=> !irq);

endmodule

bind rx_frame_ring rx_frame_ring_chk #(.NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .pending(pending), .rd_data(rd_data),
    .irq(irq), .irq_mask(irq_mask), .data_rd(data_rd), .cnt_wr(cnt_wr),
    .cnt_wdata(cnt_wdata), .sta_wr(sta_wr), .sta_wdata(sta_wdata),
    .commit(commit)
);

// File: tb/rx_frame_ring_tb_top.sv
module rx_frame_ring_tb_top;

    localparam int NS   = 3;
    localparam int SB   = 128;
    localparam int CW   = $clog2(NS + 1);
    localparam int MAXD = SB - 8;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          rx_en = 1'b0, rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
    logic [7:0]    rx_data = 8'h0;
    logic          data_rd = 1'b0, cnt_wr = 1'b0, sta_wr = 1'b0;
    logic [31:0]   cnt_wdata = 32'h0, sta_wdata = 32'h0, irq_mask = 32'h0;
    logic [31:0]   rd_data;
    logic [CW-1:0] pending;
    logic          irq;

    rx_frame_ring #(.NUM_SLOTS(NS), .SLOT_BYTES(SB)) dut_i (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .data_rd(data_rd), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .sta_wr(sta_wr), .sta_wdata(sta_wdata), .irq_mask(irq_mask),
        .rd_data(rd_data), .pending(pending), .irq(irq)
    );

    always #5 clk = ~clk;

    int total = 0, bad = 0, cyc = 0;
    bit finished = 1'b0;

    // Behavioural model state
    logic [31:0] mq[$];
    int          msz[$];
    logic [7:0]  ib[$];
    logic [31:0] cw[$];
    bit          i_on = 1'b0, i_acc = 1'b0, m_flag = 1'b0;
    int          c_at = -1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected slot image of a frame: marker, length word, padded bytes, FCS.
    task automatic build_frame();
        logic [7:0]  p[$];
        logic [31:0] c, w;
        bit          fb;
        p = ib;
        while (p.size() < 60) p.push_back(8'h00);
        c = 32'hFFFF_FFFF;
        foreach (p[i]) begin
            for (int k = 0; k < 8; k++) begin
                fb = c[0] ^ p[i][k];
                c  = {1'b0, c[31:1]};
                if (fb) c = c ^ 32'hEDB8_8320;
            end
        end
        c = ~c;
        for (int k = 0; k < 4; k++) p.push_back(c[8*k +: 8]);
        cw.delete();
        cw.push_back(32'h0143_414D);
        cw.push_back({16'h0080, 16'(p.size())});
        for (int i = 0; i < p.size(); i += 4) begin
            w = 32'h0;
            for (int k = 0; k < 4; k++)
                if (i + k < p.size()) w[8*k +: 8] = p[i + k];
            cw.push_back(w);
        end
    endtask

    // Reference model, stepped and compared on every clock
    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete(); msz.delete(); ib.delete();
            i_on = 0; i_acc = 0; m_flag = 0; c_at = -1;
        end else begin
            cyc++;
            if (rx_valid) begin
                if (rx_sof) begin
                    ib.delete();
                    i_on  = 1;
                    i_acc = rx_en && (msz.size() < NS);
                end
                if (i_on) begin
                    if (ib.size() == MAXD) i_acc = 0;
                    else ib.push_back(rx_data);
                end
                if (rx_eof && i_on) begin
                    i_on = 0;
                    if (i_acc) begin
                        build_frame();
                        c_at = cyc + ((ib.size() < 60) ? 60 - ib.size() : 0) + 5;
                    end
                end
            end
            if (cnt_wr && cnt_wdata == 32'h0) begin
                mq.delete(); msz.delete();
            end else if (data_rd && msz.size() != 0) begin
                void'(mq.pop_front());
                msz[0]--;
                if (msz[0] == 0) void'(msz.pop_front());
            end
            if (sta_wr && sta_wdata[8]) m_flag = 0;
            if (cyc == c_at) begin
                foreach (cw[i]) mq.push_back(cw[i]);
                msz.push_back(cw.size());
                m_flag = 1;
                c_at   = -1;
            end
        end
        #2;
        chk("R8 R12 pending", 32'(pending), 32'(msz.size()));
        chk("R11 irq", 32'(irq), 32'(m_flag & irq_mask[8]));
        chk("R4 R5 R6 R7 R8 rd_data", rd_data, (msz.size() == 0) ? 32'h0 : mq[0]);
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data  = 8'((seed * 37 + i * 13 + 5) & 255);
            rx_sof   = (i == 0);
            rx_eof   = (i == n - 1);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
        idle(((n < 60) ? 60 - n : 0) + 8);
    endtask

    task automatic read_n(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            data_rd = 1'b1;
        end
        @(negedge clk);
        data_rd = 1'b0;
    endtask

    task automatic write_cnt(input logic [31:0] v);
        @(negedge clk); cnt_wr = 1'b1; cnt_wdata = v;
        @(negedge clk); cnt_wr = 1'b0;
    endtask

    task automatic write_sta(input logic [31:0] v);
        @(negedge clk); sta_wr = 1'b1; sta_wdata = v;
        @(negedge clk); sta_wr = 1'b0;
    endtask

    initial begin
        idle(3);
        chk("R9 reset pending", 32'(pending), 32'h0);
        chk("R9 reset rd_data", rd_data, 32'h0);
        chk("R11 reset irq", 32'(irq), 32'h0);
        rst_n = 1'b1;
        irq_mask = 32'h0000_0100;
        rx_en = 1'b1;
        idle(2);

        send_frame(10, 1);
        chk("R4 short frame stored", 32'(pending), 32'd1);
        chk("R11 irq after store", 32'(irq), 32'd1);
        chk("R6 marker word", rd_data, 32'h0143_414D);
        read_n(1);
        chk("R6 length word", rd_data, 32'h0080_0040);
        read_n(17);
        chk("R8 frame retired", 32'(pending), 32'd0);

        send_frame(61, 2);
        read_n(19);
        chk("R7 odd length retired", 32'(pending), 32'd0);

        write_sta(32'h0000_0001);
        chk("R11 clear without bit 8", 32'(irq), 32'd1);
        write_sta(32'h0000_0100);
        chk("R11 write-one clear", 32'(irq), 32'd0);

        rx_en = 1'b0;
        send_frame(20, 3);
        chk("R1 disabled drop", 32'(pending), 32'd0);
        rx_en = 1'b1;

        send_frame(30, 4);
        send_frame(64, 5);
        send_frame(70, 6);
        chk("R3 ring filled", 32'(pending), 32'd3);
        send_frame(40, 7);
        chk("R3 full drop", 32'(pending), 32'd3);
        read_n(18);
        chk("R12 head advanced", 32'(pending), 32'd2);
        send_frame(45, 8);
        chk("R12 wrapped store", 32'(pending), 32'd3);
        read_n(19 + 21 + 18);
        chk("R12 drained in order", 32'(pending), 32'd0);

        send_frame(MAXD + 1, 9);
        chk("R2 oversize drop", 32'(pending), 32'd0);
        send_frame(MAXD, 10);
        chk("R2 capacity frame stored", 32'(pending), 32'd1);

        write_cnt(32'd5);
        chk("R10 nonzero write ignored", 32'(pending), 32'd1);
        write_cnt(32'd0);
        chk("R10 flush", 32'(pending), 32'd0);

        read_n(3);
        chk("R9 empty read pending", 32'(pending), 32'd0);
        chk("R9 empty read data", rd_data, 32'h0);

        idle(4);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule